// File: doc/BRIEF.md
# Replicate-Padded 3x3 Neighbourhood Generator

This block takes a raster stream of 8-bit grayscale pixels, one per clock while the enable is high. A frame-start marker comes with the first pixel of each frame, and a line-start marker comes with the first pixel of each line. For every pixel position of the frame, the block emits the 3x3 neighbourhood centred on that position. It is the front end for stride-1 3x3 filters such as edge detectors, and it leaves all arithmetic to the stage that follows.

Positions outside the image are filled from the nearest edge pixel. The row above the image repeats the first row and the row below repeats the last row. The columns beyond the left and right edges repeat the edge columns, and the corners follow the same rule. Each frame therefore yields exactly as many windows as it has pixels.

Two line buffers hold the earlier rows. Because of this, the windows for image row r come out while row r+1 is arriving. The last row is produced during the blanking gap after the frame, and it uses itself as its own lower neighbour.

Top module: `rep3x3_window`

## Requirements
- R1: While reset is held and after it is released with no input, out_de, out_hsync and out_vsync are low.
- R2: Each frame of IMG_W x IMG_H pixels produces exactly IMG_W*IMG_H windows, in row-major order, with out_row and out_col giving the centre position.
- R3: Element i of the window sits in out_win[8*i+7:8*i]. Elements are in row-major order: 0 is top-left, 4 is the centre pixel at (out_row, out_col), and 8 is bottom-right.
- R4: For an interior centre (r,c), element 3*a+b equals input pixel (r+a-1, c+b-1).
- R5: For centres in row 0, the top three elements repeat the row 0 pixels of the same columns.
- R6: For centres in the last row, the bottom three elements repeat the last row's pixels. These windows are produced after the frame's last pixel with no further input.
- R7: For centres in column 0 or column IMG_W-1, the missing left or right elements repeat the edge column. This includes the corners.
- R8: out_hsync is high exactly on windows whose centre is in column 0. out_vsync is high exactly on the window centred at (0,0). Both are low whenever out_de is low.
- R9: Lines may be separated by any number of idle cycles of one or more. A frame must be followed by at least IMG_W+2 idle cycles before the next frame-start.
- R10: Successive frames are independent. The frame-start marker restarts the row count, and no pixel of an earlier frame appears in a later frame's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_de | input | 1 | Input pixel valid |
| in_vsync | input | 1 | High with the first pixel of a frame |
| in_hsync | input | 1 | High with the first pixel of each line |
| in_pix | input | 8 | Input pixel |
| out_de | output | 1 | Window valid |
| out_vsync | output | 1 | Window centred at (0,0) |
| out_hsync | output | 1 | Window centred in column 0 |
| out_row | output | 12 | Row of the window centre |
| out_col | output | 12 | Column of the window centre |
| out_win | output | 72 | Nine 8-bit elements, element i at bits 8i+7..8i |

## Verification
The bench builds the block with a 5-column, 4-row image. At that size every window of every frame can be compared against a model that pads the image by clamping coordinates. All four corners, all edge kinds and the interior are covered several times per frame. Six back-to-back frames exercise random, ramp, constant and extreme-value pixels. Line gaps run from 1 to 20 cycles, and frame gaps include the minimum of IMG_W+2 idle cycles, so the flush of the last row runs into the next frame.

// File: rtl/rep3x3_pkg.sv
package rep3x3_pkg;

    localparam int PIX_W   = 8;
    localparam int COORD_W = 12;
    localparam int WIN_N   = 9;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [COORD_W-1:0] coord_t;

    // one vertical slice of the neighbourhood
    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } colv_t;

    typedef struct packed {
        logic   valid;
        coord_t row;
        coord_t col;
        colv_t  v;
    } cbeat_t;

    typedef logic [WIN_N-1:0][PIX_W-1:0] win9_t;

    typedef struct packed {
        logic   valid;
        logic   hs;
        logic   vs;
        coord_t row;
        coord_t col;
        win9_t  px;
    } wbeat_t;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_GAP  = 2'd1,
        FL_RUN  = 2'd2
    } flush_e;

    function automatic int addr_bits(input int n);
        int b;
        b = $clog2(n);
        return (b < 1) ? 1 : b;
    endfunction

    // row-major assembly: left, centre, right slices
    function automatic win9_t make_win(input colv_t l, input colv_t c, input colv_t r);
        win9_t w;
        w[0] = l.top; w[1] = c.top; w[2] = r.top;
        w[3] = l.mid; w[4] = c.mid; w[5] = r.mid;
        w[6] = l.bot; w[7] = c.bot; w[8] = r.bot;
        return w;
    endfunction

endpackage

// File: rtl/rep3x3_linebuf.sv
module rep3x3_linebuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read sees the value before a same-cycle write
    assign rdata = mem[raddr];

endmodule

// File: rtl/rep3x3_colsrc.sv
module rep3x3_colsrc
    import rep3x3_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_de,
    input  logic   in_vsync,
    input  logic   in_hsync,
    input  pix_t   in_pix,
    output cbeat_t cs
);

    localparam int AW    = addr_bits(IMG_W);
    localparam int DEPTH = 1 << AW;
    localparam int NLB   = 2;
    localparam coord_t LAST_COL = coord_t'(IMG_W - 1);
    localparam coord_t LAST_ROW = coord_t'(IMG_H - 1);

    coord_t col_ctr, row_ctr, pos_col, pos_row;
    flush_e fl_state;
    coord_t fl_col;
    logic   live, last_px, flushing;
    logic [AW-1:0] rd_addr;
    pix_t   lb_in  [NLB+1];
    pix_t   lb_out [NLB];
    cbeat_t beat;

    always_comb begin
        pos_col = (in_vsync || in_hsync) ? '0 : col_ctr;
        if (in_vsync)      pos_row = '0;
        else if (in_hsync) pos_row = row_ctr + coord_t'(1);
        else               pos_row = row_ctr;
    end

    assign live     = in_de && (pos_row != '0);
    assign last_px  = in_de && (pos_col == LAST_COL) && (pos_row == LAST_ROW);
    assign flushing = (fl_state == FL_RUN);
    assign rd_addr  = flushing ? fl_col[AW-1:0] : pos_col[AW-1:0];

    // line buffer chain: [0] holds the newest stored row, [1] the one before
    assign lb_in[0] = in_pix;
    generate
        for (genvar i = 0; i < NLB; i++) begin : g_lb
            rep3x3_linebuf #(.DW(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_lb (
                .clk   (clk),
                .we    (in_de),
                .waddr (pos_col[AW-1:0]),
                .wdata (lb_in[i]),
                .raddr (rd_addr),
                .rdata (lb_out[i])
            );
            assign lb_in[i+1] = lb_out[i];
        end
    endgenerate

    always_comb begin
        beat = '0;
        if (flushing) begin
            beat.valid = 1'b1;
            beat.row   = LAST_ROW;
            beat.col   = fl_col;
            beat.v.mid = lb_out[0];
            beat.v.bot = lb_out[0];
            beat.v.top = (LAST_ROW == '0) ? lb_out[0] : lb_out[1];
        end else if (live) begin
            beat.valid = 1'b1;
            beat.row   = pos_row - coord_t'(1);
            beat.col   = pos_col;
            beat.v.mid = lb_out[0];
            beat.v.bot = in_pix;
            beat.v.top = (pos_row == coord_t'(1)) ? lb_out[0] : lb_out[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_ctr  <= '0;
            row_ctr  <= '0;
            fl_state <= FL_IDLE;
            fl_col   <= '0;
            cs       <= '0;
        end else begin
            cs <= beat;
            if (in_de) begin
                col_ctr <= pos_col + coord_t'(1);
                row_ctr <= pos_row;
            end
            case (fl_state)
                FL_IDLE: if (last_px) fl_state <= FL_GAP;
                FL_GAP: begin
                    fl_state <= FL_RUN;
                    fl_col   <= '0;
                end
                FL_RUN: begin
                    if (fl_col == LAST_COL) fl_state <= FL_IDLE;
                    else                    fl_col   <= fl_col + coord_t'(1);
                end
                default: fl_state <= FL_IDLE;
            endcase
        end
    end

    // R9: the next frame must not start before the last row has been flushed
    a_r9_frame_gap: assert property (@(posedge clk) disable iff (rst)
        (fl_state != FL_IDLE) |-> !in_de);

    // R6: a flush starts one idle cycle after the final pixel
    a_r6_flush_start: assert property (@(posedge clk) disable iff (rst)
        last_px |=> (fl_state == FL_GAP));

endmodule

// File: rtl/rep3x3_hshift.sv
module rep3x3_hshift
    import rep3x3_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48
) (
    input  logic   clk,
    input  logic   rst,
    input  cbeat_t cs,
    output wbeat_t wo
);

    localparam coord_t LAST_COL = coord_t'(IMG_W - 1);
    localparam coord_t LAST_ROW = coord_t'(IMG_H - 1);

    colv_t  q_l, q_c;
    logic   pend;
    coord_t pend_row;

    function automatic wbeat_t emit(input colv_t l, input colv_t c, input colv_t r,
                                    input coord_t row, input coord_t col);
        wbeat_t b;
        b.valid = 1'b1;
        b.row   = row;
        b.col   = col;
        b.hs    = (col == '0);
        b.vs    = (col == '0) && (row == '0);
        b.px    = make_win(l, c, r);
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            q_l      <= '0;
            q_c      <= '0;
            pend     <= 1'b0;
            pend_row <= '0;
            wo       <= '0;
        end else begin
            wo.valid <= 1'b0;
            wo.hs    <= 1'b0;
            wo.vs    <= 1'b0;
            if (cs.valid) begin
                if (cs.col == '0) begin
                    // left edge: the first slice stands in for its own left neighbour
                    q_l <= cs.v;
                    q_c <= cs.v;
                end else begin
                    wo  <= emit(q_l, q_c, cs.v, cs.row, cs.col - coord_t'(1));
                    q_l <= q_c;
                    q_c <= cs.v;
                end
                pend     <= (cs.col == LAST_COL);
                pend_row <= cs.row;
            end else if (pend) begin
                // right edge: last slice repeated as the right neighbour
                wo   <= emit(q_l, q_c, q_c, pend_row, LAST_COL);
                pend <= 1'b0;
            end
        end
    end

    // R9: a line's pending right-edge window needs one idle slot
    a_r9_line_gap: assert property (@(posedge clk) disable iff (rst)
        pend |-> !cs.valid);

    // R7: left and right edge columns are replicated
    a_r7_left_edge: assert property (@(posedge clk) disable iff (rst)
        (wo.valid && wo.col == '0) |->
            (wo.px[0] == wo.px[1] && wo.px[3] == wo.px[4] && wo.px[6] == wo.px[7]));
    a_r7_right_edge: assert property (@(posedge clk) disable iff (rst)
        (wo.valid && wo.col == LAST_COL) |->
            (wo.px[2] == wo.px[1] && wo.px[5] == wo.px[4] && wo.px[8] == wo.px[7]));

    // R5 / R6: top and bottom edge rows are replicated
    a_r5_top_edge: assert property (@(posedge clk) disable iff (rst)
        (wo.valid && wo.row == '0) |->
            (wo.px[0] == wo.px[3] && wo.px[1] == wo.px[4] && wo.px[2] == wo.px[5]));
    a_r6_bottom_edge: assert property (@(posedge clk) disable iff (rst)
        (wo.valid && wo.row == LAST_ROW) |->
            (wo.px[6] == wo.px[3] && wo.px[7] == wo.px[4] && wo.px[8] == wo.px[5]));

    // R8: markers never appear without a window
    a_r8_marker_valid: assert property (@(posedge clk) disable iff (rst)
        (wo.hs || wo.vs) |-> wo.valid);

endmodule

// File: rtl/rep3x3_window.sv
module rep3x3_window
    import rep3x3_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_de,
    input  logic                     in_vsync,
    input  logic                     in_hsync,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     out_de,
    output logic                     out_vsync,
    output logic                     out_hsync,
    output logic [COORD_W-1:0]       out_row,
    output logic [COORD_W-1:0]       out_col,
    output logic [WIN_N*PIX_W-1:0]   out_win
);

    cbeat_t cs;
    wbeat_t wo;

    initial begin
        a_r2_dims: assert (IMG_W >= 2 && IMG_H >= 2 &&
                           IMG_W < (1 << COORD_W) && IMG_H < (1 << COORD_W));
    end

    rep3x3_colsrc #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_colsrc (
        .clk      (clk),
        .rst      (rst),
        .in_de    (in_de),
        .in_vsync (in_vsync),
        .in_hsync (in_hsync),
        .in_pix   (in_pix),
        .cs       (cs)
    );

    rep3x3_hshift #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_hshift (
        .clk (clk),
        .rst (rst),
        .cs  (cs),
        .wo  (wo)
    );

    assign out_de    = wo.valid;
    assign out_vsync = wo.vs;
    assign out_hsync = wo.hs;
    assign out_row   = wo.row;
    assign out_col   = wo.col;
    assign out_win   = wo.px;

    // R2: consecutive windows within a line advance by one column
    a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
        (out_de && $past(out_de) && out_col != '0) |-> (out_col == $past(out_col) + 1'b1));

endmodule

// File: tb/rep3x3_window_test.sv
`timescale 1ns/1ps
module rep3x3_window_test;

    localparam int TW = 5;
    localparam int TH = 4;
    localparam int NF = 6;
    localparam int NP = TW * TH;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_de = 1'b0, in_vsync = 1'b0, in_hsync = 1'b0;
    logic [7:0]  in_pix = '0;
    logic        out_de, out_vsync, out_hsync;
    logic [11:0] out_row, out_col;
    logic [71:0] out_win;

    int checks = 0;
    int errors = 0;
    int fcnt   = 0;
    int idx    = 0;
    bit done   = 1'b0;
    logic [7:0] frm [NF][NP];

    always #10 clk = ~clk;

    rep3x3_window #(.IMG_W(TW), .IMG_H(TH)) uut (
        .clk(clk), .rst(rst), .in_de(in_de), .in_vsync(in_vsync), .in_hsync(in_hsync),
        .in_pix(in_pix), .out_de(out_de), .out_vsync(out_vsync), .out_hsync(out_hsync),
        .out_row(out_row), .out_col(out_col), .out_win(out_win)
    );

    task automatic check(input bit ok, input string req, input logic [71:0] act,
                         input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    // monitor: compares every window with a clamped-coordinate model
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (!out_de) begin
                check(!out_hsync && !out_vsync, "R8", {out_hsync, out_vsync}, 72'd0);
            end else begin
                if (out_vsync) begin
                    if (fcnt > 0) check(idx == NP, "R2", idx, NP);
                    fcnt++;
                    idx = 0;
                end
                if (fcnt >= 1 && fcnt <= NF) begin
                    automatic int r = idx / TW;
                    automatic int c = idx % TW;
                    automatic logic [71:0] exp = '0;
                    automatic string tag;
                    for (int i = 0; i < 9; i++) begin
                        automatic int rr = clampi(r + i / 3 - 1, TH - 1);
                        automatic int cc = clampi(c + i % 3 - 1, TW - 1);
                        exp[8*i +: 8] = frm[fcnt-1][rr*TW + cc];
                    end
                    if (r == 0)                      tag = "R5";
                    else if (r == TH - 1)            tag = "R6";
                    else if (c == 0 || c == TW - 1)  tag = "R7";
                    else                             tag = "R4";
                    check(out_win == exp, tag, out_win, exp);
                    // R3: centre element at bits 39:32
                    check(out_win[39:32] == frm[fcnt-1][r*TW + c], "R3",
                          out_win[39:32], frm[fcnt-1][r*TW + c]);
                    check(out_row == r && out_col == c, "R2",
                          {out_row, out_col}, {12'(r), 12'(c)});
                    check(out_hsync == (c == 0) && out_vsync == (r == 0 && c == 0), "R8",
                          {out_hsync, out_vsync}, {(c == 0), (r == 0 && c == 0)});
                end else begin
                    check(1'b0, "R10", fcnt, NF);
                end
                idx++;
            end
        end
    end

    task automatic send_frame(input int f, input int fgap);
        for (int r = 0; r < TH; r++) begin
            for (int c = 0; c < TW; c++) begin
                @(negedge clk);
                in_de    = 1'b1;
                in_vsync = (r == 0 && c == 0);
                in_hsync = (c == 0);
                in_pix   = frm[f][r*TW + c];
            end
            @(negedge clk);
            in_de = 1'b0; in_vsync = 1'b0; in_hsync = 1'b0;
            if (r != TH - 1) repeat ((r * 7 + f * 3) % 20) @(negedge clk); // R9 gaps 1..20
        end
        repeat (fgap - 1) @(negedge clk);
    endtask

    initial begin
        for (int f = 0; f < NF; f++)
            for (int p = 0; p < NP; p++) begin
                case (f)
                    1:       frm[f][p] = 8'((p * 13) & 8'hff);
                    2:       frm[f][p] = 8'ha5;
                    3:       frm[f][p] = ((p / TW + p % TW) % 2 == 1) ? 8'hff : 8'h00;
                    default: frm[f][p] = 8'($urandom);
                endcase
            end
        repeat (3) @(negedge clk);
        // R1: quiet while held in reset
        check(!out_de && !out_hsync && !out_vsync, "R1",
              {out_de, out_hsync, out_vsync}, 72'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!out_de && !out_hsync && !out_vsync, "R1",
              {out_de, out_hsync, out_vsync}, 72'd0);
        // R9: frame gaps, including the minimum of TW+2 idle cycles; R10: six frames
        send_frame(0, TW + 10);
        send_frame(1, TW + 2);
        send_frame(2, 40);
        send_frame(3, TW + 2);
        send_frame(4, TW + 2);
        send_frame(5, 30);
        repeat (10) @(negedge clk);
        done = 1'b1;
        // R6: last frame fully flushed without further input
        check(idx == NP, "R6", idx, NP);
        check(fcnt == NF, "R10", fcnt, NF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", fcnt, NF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule